// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks lock reservations that load-linked operations place on cache lines, and judges each store-conditional against them. It watches completed memory operations. Each completion comes as a one-cycle strobe with a line address, an operation kind and a requester id. A load-linked sets a reservation on its line tagged with the requester id. A store-conditional succeeds only while that reservation is still held by the same id. Every store-conditional gives up the line's reservation, whether it succeeds or fails. An ordinary write by the owner also drops it.

A small table of `ENTRIES` reservations is kept. When the table is full, a load-linked to a new line displaces the reservation that was installed longest ago. An invalidate input lets the surrounding coherence logic break a reservation from outside. One cycle after each completion the block presents a success bit and a result word (1 for a successful store-conditional, 0 otherwise) for the CPU.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (kind 0) installs a reservation on its line tagged with the requester id. A load-linked to a line that already holds a reservation retags it to the new id without taking another entry.
- R2: A store-conditional (kind 1) succeeds only if its line holds a reservation tagged with the same id. On success `sc_ok` is 1 and `sc_word` is 1. On failure both are 0.
- R3: Every store-conditional removes any reservation on its line, so a second store-conditional to that line fails.
- R4: An ordinary write (kind 2) removes the reservation on its line when the reservation carries the same id. A write with a different id leaves the reservation in place.
- R5: Load-linked, ordinary write and plain read completions report `sc_ok` = 1 with `sc_word` = 0.
- R6: At most `ENTRIES` reservations are held. A load-linked to a new line with all entries in use evicts the oldest installed reservation.
- R7: An invalidate (`inv_vld` with `inv_addr`) removes the matching reservation in the same cycle and wins over a completion to the same line in that cycle. A store-conditional in that cycle fails, and a load-linked in that cycle installs nothing. An entry freed by an invalidate can be reused by a load-linked in the same cycle.
- R8: `rsp_vld` is high for exactly the cycle after each completion strobe. While `rsp_vld` is low, `sc_ok` and `sc_word` are 0.
- R9: Reset empties the table and zeroes the outputs.
- R10: A plain read (kind 3) does not change any reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_vld | input | 1 | Completion strobe |
| done_addr | input | ADDR_W | Line address of the completion |
| done_kind | input | 2 | 0 load-linked, 1 store-conditional, 2 write, 3 read |
| done_id | input | ID_W | Requester id |
| inv_vld | input | 1 | External reservation clear |
| inv_addr | input | ADDR_W | Line address to clear |
| rsp_vld | output | 1 | Response valid, one cycle after the strobe |
| sc_ok | output | 1 | Success flag |
| sc_word | output | RES_W | Store-conditional result word |

## Verification
The hardest case to reach is an eviction decided on a table whose contents are changing in the same cycle. This happens when an invalidate frees one entry while a load-linked to a new line arrives, or after removals have left gaps between entries of different ages. The bench gets there with a long sweep over only six line addresses and two ids against a four-entry table, with invalidates mixed in. This keeps the table full and churning. A reference list kept in insertion order predicts every store-conditional outcome, so a wrong victim shows up as a wrong result later on.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int ENTRIES = 4,
  parameter int RES_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_vld,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic [1:0]        done_kind,
  input  logic [ID_W-1:0]   done_id,
  input  logic              inv_vld,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              rsp_vld,
  output logic              sc_ok,
  output logic [RES_W-1:0]  sc_word
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld, vld_eff, line_hit, own_hit;
  logic [ADDR_W-1:0]  tag   [ENTRIES];
  logic [ID_W-1:0]    owner [ENTRIES];
  logic [IDX_W-1:0]   rank  [ENTRIES];

  logic             free_any;
  logic [IDX_W-1:0] free_idx, old_idx, victim, victim_rank;

  wire is_ll = done_vld && done_kind == 2'd0;
  wire is_sc = done_vld && done_kind == 2'd1;
  wire is_wr = done_vld && done_kind == 2'd2;
  wire kill  = inv_vld && inv_addr == done_addr;
  wire alloc = is_ll && !(|line_hit) && !kill;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_eff[i]  = vld[i] && !(inv_vld && tag[i] == inv_addr);
      line_hit[i] = vld_eff[i] && tag[i] == done_addr;
      own_hit[i]  = line_hit[i] && owner[i] == done_id;
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_eff[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (rank[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
    end
  end

  assign victim      = free_any ? free_idx : old_idx;
  assign victim_rank = rank[victim];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]   <= 1'b0;
        tag[g]   <= '0;
        owner[g] <= '0;
        rank[g]  <= IDX_W'(g);
      end else begin
        vld[g] <= vld_eff[g] && !((is_sc && line_hit[g]) || (is_wr && own_hit[g]));
        if (is_ll && line_hit[g]) owner[g] <= done_id;
        if (alloc && victim == IDX_W'(g)) begin
          vld[g]   <= 1'b1;
          tag[g]   <= done_addr;
          owner[g] <= done_id;
          rank[g]  <= '0;
        end else if (alloc && rank[g] < victim_rank) begin
          rank[g] <= rank[g] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      sc_ok   <= 1'b0;
      sc_word <= '0;
    end else begin
      rsp_vld <= done_vld;
      sc_ok   <= done_vld && (!is_sc || |own_hit);
      sc_word <= RES_W'(is_sc && |own_hit);
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int ENTRIES = 4,
  parameter int RES_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_vld,
  input logic [ADDR_W-1:0] done_addr,
  input logic [1:0]        done_kind,
  input logic [ID_W-1:0]   done_id,
  input logic              inv_vld,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              rsp_vld,
  input logic              sc_ok,
  input logic [RES_W-1:0]  sc_word
);
  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld == $past(done_vld));
  // R8
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (!sc_ok && sc_word == '0));
  // R5
  ll_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_kind == 2'd0) |=> (sc_ok && sc_word == '0));
  // R2
  sc_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_kind == 2'd1) |=> sc_word == RES_W'(sc_ok));
  // R7
  inv_beats_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_kind == 2'd1 && inv_vld && inv_addr == done_addr) |=> !sc_ok);
  // R3
  sc_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_kind == 2'd1 && $past(done_vld && done_kind == 2'd1)
     && $past(done_addr) == done_addr) |=> !sc_ok);
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .ENTRIES(ENTRIES), .RES_W(RES_W)
) u_chk (.*);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int AW = 4, IW = 2, N = 4, RW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done_vld = 1'b0, inv_vld = 1'b0;
  logic [AW-1:0] done_addr = '0, inv_addr = '0;
  logic [1:0] done_kind = '0;
  logic [IW-1:0] done_id = '0;
  logic rsp_vld, sc_ok;
  logic [RW-1:0] sc_word;

  int checks = 0, fails = 0;
  int m_cnt = 0;
  int m_addr [N];
  int m_id [N];

  always #4 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .ID_W(IW), .ENTRIES(N), .RES_W(RW)) u_llsc_monitor (
    .clk, .rst_n, .done_vld, .done_addr, .done_kind, .done_id,
    .inv_vld, .inv_addr, .rsp_vld, .sc_ok, .sc_word);

  function automatic int m_find(int a);
    for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic m_remove(int p);
    for (int i = p; i < m_cnt - 1; i++) begin
      m_addr[i] = m_addr[i+1];
      m_id[i]   = m_id[i+1];
    end
    m_cnt--;
  endtask

  task automatic check(string req, logic v, logic ok, int w, logic ev, logic eok, int ew);
    checks++;
    if (v !== ev || ok !== eok || w !== ew) begin
      fails++;
      $display("FAIL %s: got vld=%0b ok=%0b word=%0d, expected vld=%0b ok=%0b word=%0d",
               req, v, ok, w, ev, eok, ew);
    end
  endtask

  task automatic do_op(int kind, int a, int id, bit iv, int ia, string req);
    logic eok;
    int ew, p;
    eok = 1'b1;
    ew = 0;
    if (iv) begin
      p = m_find(ia);
      if (p >= 0) m_remove(p);
    end
    p = m_find(a);
    case (kind)
      0: if (!(iv && ia == a)) begin
           if (p >= 0) m_id[p] = id;
           else begin
             if (m_cnt == N) m_remove(0);
             m_addr[m_cnt] = a;
             m_id[m_cnt] = id;
             m_cnt++;
           end
         end
      1: begin
           eok = (p >= 0 && m_id[p] == id);
           ew = eok ? 1 : 0;
           if (p >= 0) m_remove(p);
         end
      2: if (p >= 0 && m_id[p] == id) m_remove(p);
      default: ;
    endcase
    done_vld = 1'b1; done_kind = kind[1:0]; done_addr = a[AW-1:0]; done_id = id[IW-1:0];
    inv_vld = iv; inv_addr = ia[AW-1:0];
    @(negedge clk);
    done_vld = 1'b0; inv_vld = 1'b0;
    check(req, rsp_vld, sc_ok, int'(sc_word), 1'b1, eok, ew);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    check(req, rsp_vld, sc_ok, int'(sc_word), 1'b0, 1'b0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: got running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle("R9 reset outputs");
    do_op(0, 1, 1, 0, 0, "R1 LL");
    do_op(1, 1, 1, 0, 0, "R1/R2 SC own line");
    do_op(1, 1, 1, 0, 0, "R3 second SC");
    do_op(0, 2, 0, 0, 0, "R1 LL");
    do_op(1, 2, 1, 0, 0, "R2 SC other id");
    do_op(1, 2, 0, 0, 0, "R3 SC after failed SC");
    do_op(0, 2, 0, 0, 0, "R1 LL");
    do_op(0, 2, 1, 0, 0, "R1 LL retag");
    do_op(1, 2, 1, 0, 0, "R1 SC retagged");
    do_op(0, 3, 1, 0, 0, "R5 LL");
    do_op(2, 3, 0, 0, 0, "R4/R5 write other id");
    do_op(1, 3, 1, 0, 0, "R4 SC survives foreign write");
    do_op(0, 3, 1, 0, 0, "R1 LL");
    do_op(2, 3, 1, 0, 0, "R4 write own id");
    do_op(1, 3, 1, 0, 0, "R4 SC after own write");
    do_op(0, 4, 2, 0, 0, "R1 LL");
    do_op(3, 4, 2, 0, 0, "R10 read");
    do_op(1, 4, 2, 0, 0, "R10 SC after read");
    for (int a = 1; a <= 5; a++) do_op(0, a, 0, 0, 0, "R6 fill");
    do_op(1, 1, 0, 0, 0, "R6 oldest evicted");
    do_op(1, 2, 0, 0, 0, "R6 survivor");
    do_op(0, 6, 0, 0, 0, "R1 LL");
    do_op(3, 0, 0, 1, 6, "R7 invalidate alone");
    do_op(1, 6, 0, 0, 0, "R7 SC after invalidate");
    do_op(0, 7, 0, 0, 0, "R1 LL");
    do_op(1, 7, 0, 1, 7, "R7 SC with same-cycle invalidate");
    do_op(0, 8, 0, 1, 8, "R7 LL with same-cycle invalidate");
    do_op(1, 8, 0, 0, 0, "R7 LL was dropped");
    idle("R8 idle");
    do_op(0, 9, 1, 0, 0, "R1 LL");
    do_reset();
    idle("R9 after reset");
    do_op(1, 9, 1, 0, 0, "R9 reservation gone");
    for (int k = 0; k < 4000; k++) begin
      int kind, a, id, ia;
      bit iv;
      kind = int'($urandom_range(3, 0));
      a    = int'($urandom_range(5, 0));
      id   = int'($urandom_range(1, 0));
      iv   = ($urandom_range(7, 0) == 0);
      ia   = int'($urandom_range(5, 0));
      do_op(kind, a, id, iv, ia, "R2/R3/R4/R6/R7 sweep");
      if ((k % 97) == 0) idle("R8 sweep idle");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule